// File: doc/BRIEF.md
# Split Code/Data Card Window Address Decoder

This block sits between a processor's 24-bit address bus and a set of three removable memory card slots. The processor marks each bus cycle as either an instruction fetch or a data access, so the block sees two separate 16 MB address spaces. The upper 8 MB of each space is a card window. A fetch in the window reaches whichever slot is currently the active code card. A data access in the window reaches whichever slot is the active data card. The same window address can therefore reach two different cards at the same time, one per access type. The window offset handed to the card is the address with the top bit removed, so data on a card reads the same whatever its place in the map.

Below the window, the block routes all accesses to the fixed system slot, which holds the boot ROM and RAM. The exception is the top 2 KB of the lower half, where the processor's own integrated peripheral registers live. There the block asserts a peripheral indication and drives no slot. Cards can be plugged in or pulled out while the system runs. The presence inputs are synchronised, and an access whose target slot has no card raises a bus error instead of a chip select.

Software picks the active code card and the active data card through a small write port. A new selection is held pending while a bus cycle is in progress and is committed only on an idle clock. A running cycle never sees its target change.

Top module: `card_window_mapper`

## Requirements
- R1: While `bus_valid` is high with `bus_addr[23]`=1 and `bus_is_code`=1, exactly the active code card's bit of `slot_cs` is set, and `card_offset` equals `bus_addr[22:0]`, provided that slot is present.
- R2: While `bus_valid` is high with `bus_addr[23]`=1 and `bus_is_code`=0, exactly the active data card's bit of `slot_cs` is set, and `card_offset` equals `bus_addr[22:0]`, provided that slot is present.
- R3: An access with `bus_addr` below 0x7FF800 selects the system slot 0 (`slot_cs`=3'b001) with `card_offset`=`bus_addr[22:0]`, for either value of `bus_is_code`.
- R4: An access with `bus_addr` in 0x7FF800..0x7FFFFF sets `periph_sel`. It leaves `slot_cs` at zero and `bus_err` low.
- R5: An access whose target slot is reported absent sets `bus_err`, with `slot_cs`=0 and `card_offset`=0.
- R6: A change on `slot_present[i]` reaches the decode after exactly two rising clock edges.
- R7: A write on the select port is committed at the first rising edge where `bus_valid` is low. A write made while idle is used from the next clock. A write made during a cycle never changes that cycle's target.
- R8: A write with `reg_wr_slot` of 3 or more is ignored, and the selection stays unchanged. `reg_wr_target`=0 selects the code register and 1 selects the data register.
- R9: While `bus_valid` is low, `slot_cs`, `card_offset`, `periph_sel` and `bus_err` are all zero.
- R10: After reset, both the active code card and the active data card are slot 0, and every slot reads as absent until its presence input has been synchronised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus cycle in progress (idle for at least one clock between cycles) |
| bus_addr | input | 24 | Processor address |
| bus_is_code | input | 1 | 1 = instruction fetch, 0 = data access |
| reg_wr_en | input | 1 | Select-port write strobe |
| reg_wr_target | input | 1 | 0 = active code card, 1 = active data card |
| reg_wr_slot | input | 2 | Slot number to make active |
| slot_present | input | 3 | Card-detect per slot, asynchronous |
| slot_cs | output | 3 | One-hot slot chip select |
| card_offset | output | 23 | Card-relative offset |
| periph_sel | output | 1 | Access falls in the integrated peripheral range |
| bus_err | output | 1 | Access targets an absent card |

## Verification
On every cycle, the assertions check several properties. `slot_cs` is at most one-hot, and a bus error never coexists with a chip select. The peripheral range and idle cycles leave the slots untouched. A selected window access carries the stripped offset, and the lower half always lands on the system slot. A further assertion checks that the committed card selections never move on the edge after a busy cycle. Some behaviours can only be shown by the bench's scenarios comparing against its reference model. These are the two-edge delay of card-detect changes, the deferral of a mid-cycle selection write to the following cycle, the dropping of out-of-range slot numbers, and the same window address reaching different slots for fetches and data.

// File: rtl/cwm_pkg.sv
package cwm_pkg;

    localparam int CWM_ADDR_W     = 24;
    localparam int CWM_NUM_SLOTS  = 3;
    localparam int CWM_SYS_SLOT   = 0;
    localparam int CWM_PERIPH_AW  = 11;
    localparam int CWM_SYNC_STAGES = 2;

    // Which selection register a write addresses
    typedef enum logic {
        SPC_CODE = 1'b0,
        SPC_DATA = 1'b1
    } cwm_space_e;

    // Decode region of one access
    typedef enum logic [1:0] {
        RGN_IDLE   = 2'd0,
        RGN_LOW    = 2'd1,
        RGN_PERIPH = 2'd2,
        RGN_WINDOW = 2'd3
    } cwm_region_e;

    // Per-access flag bundle leaving the decoder
    typedef struct packed {
        logic periph;
        logic err;
        logic hit;
    } cwm_flags_t;

    function automatic cwm_region_e classify(input logic valid, input logic top_bit,
                                             input logic periph_ones);
        if (!valid)
            return RGN_IDLE;
        else if (top_bit)
            return RGN_WINDOW;
        else if (periph_ones)
            return RGN_PERIPH;
        else
            return RGN_LOW;
    endfunction

endpackage

// File: rtl/cwm_presence_sync.sv
module cwm_presence_sync #(
    parameter int NUM_SLOTS = cwm_pkg::CWM_NUM_SLOTS,
    parameter int STAGES    = cwm_pkg::CWM_SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] present_async,
    output logic [NUM_SLOTS-1:0] present_sync
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst)
                chain <= '0;
            else if (STAGES == 1)
                chain[0] <= present_async[s];
            else
                chain <= {chain[STAGES-2:0], present_async[s]};
        end
        assign present_sync[s] = chain[STAGES-1];
    end

endmodule

// File: rtl/cwm_card_regs.sv
module cwm_card_regs
    import cwm_pkg::*;
#(
    parameter int NUM_SLOTS = CWM_NUM_SLOTS,
    parameter int SYS_SLOT  = CWM_SYS_SLOT,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              wr_en,
    input  cwm_space_e        wr_target,
    input  logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] code_card,
    output logic [SLOT_W-1:0] data_card
);

    localparam logic [SLOT_W:0]   SLOT_LIMIT = (SLOT_W+1)'(NUM_SLOTS);
    localparam logic [SLOT_W-1:0] RESET_SLOT = SLOT_W'(SYS_SLOT);

    logic [SLOT_W-1:0] pend_q [2];
    logic [SLOT_W-1:0] pend_d [2];
    logic [SLOT_W-1:0] comm_q [2];
    logic              slot_ok;

    assign slot_ok = ({1'b0, wr_slot} < SLOT_LIMIT);

    always_comb begin
        pend_d[0] = pend_q[0];
        pend_d[1] = pend_q[1];
        if (wr_en && slot_ok) begin
            if (wr_target == SPC_DATA)
                pend_d[1] = wr_slot;
            else
                pend_d[0] = wr_slot;
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[k] <= RESET_SLOT;
                comm_q[k] <= RESET_SLOT;
            end else begin
                pend_q[k] <= pend_d[k];
                if (!bus_valid)
                    comm_q[k] <= pend_d[k];
            end
        end
    end

    assign code_card = comm_q[0];
    assign data_card = comm_q[1];

endmodule

// File: rtl/cwm_decode.sv
module cwm_decode
    import cwm_pkg::*;
#(
    parameter int ADDR_W    = CWM_ADDR_W,
    parameter int NUM_SLOTS = CWM_NUM_SLOTS,
    parameter int SYS_SLOT  = CWM_SYS_SLOT,
    parameter int PERIPH_AW = CWM_PERIPH_AW,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int OFF_W    = ADDR_W - 1
) (
    input  logic                 valid,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 is_code,
    input  logic [SLOT_W-1:0]    code_card,
    input  logic [SLOT_W-1:0]    data_card,
    input  logic [NUM_SLOTS-1:0] present,
    output logic [NUM_SLOTS-1:0] cs,
    output logic [OFF_W-1:0]     offset,
    output cwm_flags_t           flags
);

    localparam logic [SLOT_W-1:0] SYS_IDX = SLOT_W'(SYS_SLOT);

    cwm_region_e       region;
    logic [SLOT_W-1:0] target;
    logic              periph_ones;
    logic              target_here;

    assign periph_ones = &addr[ADDR_W-2:PERIPH_AW];
    assign region      = classify(valid, addr[ADDR_W-1], periph_ones);

    always_comb begin
        unique case (region)
            RGN_WINDOW: target = is_code ? code_card : data_card;
            default:    target = SYS_IDX;
        endcase
    end

    assign target_here = present[target];

    always_comb begin
        cs           = '0;
        offset       = '0;
        flags        = '0;
        unique case (region)
            RGN_IDLE: ;
            RGN_PERIPH: flags.periph = 1'b1;
            RGN_LOW, RGN_WINDOW: begin
                if (target_here) begin
                    cs        = NUM_SLOTS'(1) << target;
                    offset    = addr[OFF_W-1:0];
                    flags.hit = 1'b1;
                end else begin
                    flags.err = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/card_window_mapper.sv
module card_window_mapper
    import cwm_pkg::*;
#(
    parameter int ADDR_W    = CWM_ADDR_W,
    parameter int NUM_SLOTS = CWM_NUM_SLOTS,
    parameter int SYS_SLOT  = CWM_SYS_SLOT,
    parameter int PERIPH_AW = CWM_PERIPH_AW,
    parameter int STAGES    = CWM_SYNC_STAGES,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int OFF_W    = ADDR_W - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_is_code,
    input  logic                 reg_wr_en,
    input  logic                 reg_wr_target,
    input  logic [SLOT_W-1:0]    reg_wr_slot,
    input  logic [NUM_SLOTS-1:0] slot_present,
    output logic [NUM_SLOTS-1:0] slot_cs,
    output logic [OFF_W-1:0]     card_offset,
    output logic                 periph_sel,
    output logic                 bus_err
);

    logic [NUM_SLOTS-1:0] present_sync;
    logic [SLOT_W-1:0]    code_card;
    logic [SLOT_W-1:0]    data_card;
    cwm_flags_t           flags;
    cwm_space_e           wr_space;

    assign wr_space = cwm_space_e'(reg_wr_target);

    cwm_presence_sync #(
        .NUM_SLOTS (NUM_SLOTS),
        .STAGES    (STAGES)
    ) i_sync (
        .clk           (clk),
        .rst           (rst),
        .present_async (slot_present),
        .present_sync  (present_sync)
    );

    cwm_card_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .SYS_SLOT  (SYS_SLOT)
    ) i_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .wr_en     (reg_wr_en),
        .wr_target (wr_space),
        .wr_slot   (reg_wr_slot),
        .code_card (code_card),
        .data_card (data_card)
    );

    cwm_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_SLOTS (NUM_SLOTS),
        .SYS_SLOT  (SYS_SLOT),
        .PERIPH_AW (PERIPH_AW)
    ) i_dec (
        .valid     (bus_valid),
        .addr      (bus_addr),
        .is_code   (bus_is_code),
        .code_card (code_card),
        .data_card (data_card),
        .present   (present_sync),
        .cs        (slot_cs),
        .offset    (card_offset),
        .flags     (flags)
    );

    assign periph_sel = flags.periph;
    assign bus_err    = flags.err;

endmodule

// File: rtl/cwm_checker.sv
module cwm_checker #(
    parameter int ADDR_W    = 24,
    parameter int NUM_SLOTS = 3,
    parameter int SYS_SLOT  = 0,
    parameter int PERIPH_AW = 11,
    parameter int SLOT_W    = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_valid,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [NUM_SLOTS-1:0] slot_cs,
    input logic [ADDR_W-2:0]    card_offset,
    input logic                 periph_sel,
    input logic                 bus_err,
    input logic [SLOT_W-1:0]    code_card,
    input logic [SLOT_W-1:0]    data_card
);

    logic in_window;
    logic in_periph;
    assign in_window = bus_addr[ADDR_W-1];
    assign in_periph = !bus_addr[ADDR_W-1] && (&bus_addr[ADDR_W-2:PERIPH_AW]);

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_cs));

    // R2
    window_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && in_window && slot_cs != '0) |-> card_offset == bus_addr[ADDR_W-2:0]);

    // R3
    low_system_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !in_window && !in_periph && !bus_err)
            |-> (slot_cs == (NUM_SLOTS'(1) << SYS_SLOT) && card_offset == bus_addr[ADDR_W-2:0]));

    // R4
    periph_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && in_periph) |-> (periph_sel && slot_cs == '0 && !bus_err));

    // R5
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (slot_cs == '0 && card_offset == '0 && !periph_sel));

    // R7
    commit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_valid) && !$past(rst)) |-> ($stable(code_card) && $stable(data_card)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> (slot_cs == '0 && card_offset == '0 && !periph_sel && !bus_err));

endmodule

bind card_window_mapper cwm_checker #(
    .ADDR_W    (ADDR_W),
    .NUM_SLOTS (NUM_SLOTS),
    .SYS_SLOT  (SYS_SLOT),
    .PERIPH_AW (PERIPH_AW),
    .SLOT_W    (SLOT_W)
) i_cwm_checker (
    .clk         (clk),
    .rst         (rst),
    .bus_valid   (bus_valid),
    .bus_addr    (bus_addr),
    .slot_cs     (slot_cs),
    .card_offset (card_offset),
    .periph_sel  (periph_sel),
    .bus_err     (bus_err),
    .code_card   (code_card),
    .data_card   (data_card)
);

// File: tb/test_card_window_mapper.sv
`timescale 1ns/1ps
module test_card_window_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        d_valid = 1'b0;
    logic [23:0] d_addr = '0;
    logic        d_code = 1'b0;
    logic        d_wr = 1'b0;
    logic        d_tgt = 1'b0;
    logic [1:0]  d_slot = '0;
    logic [2:0]  d_pres = 3'b111;

    logic [2:0]  slot_cs;
    logic [22:0] card_offset;
    logic        periph_sel;
    logic        bus_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    card_window_mapper i_card_window_mapper (
        .clk           (clk),
        .rst           (rst),
        .bus_valid     (d_valid),
        .bus_addr      (d_addr),
        .bus_is_code   (d_code),
        .reg_wr_en     (d_wr),
        .reg_wr_target (d_tgt),
        .reg_wr_slot   (d_slot),
        .slot_present  (d_pres),
        .slot_cs       (slot_cs),
        .card_offset   (card_offset),
        .periph_sel    (periph_sel),
        .bus_err       (bus_err)
    );

    // Behavioural reference state
    int         m_pend [2];
    int         m_comm [2];
    logic [2:0] m_s1, m_s2;

    always @(posedge clk) begin
        if (rst) begin
            m_pend[0] = 0; m_pend[1] = 0;
            m_comm[0] = 0; m_comm[1] = 0;
            m_s1 = '0; m_s2 = '0;
        end else begin
            m_s2 = m_s1;
            m_s1 = d_pres;
            if (d_wr && d_slot < 3) m_pend[d_tgt] = d_slot;
            if (!d_valid) begin
                m_comm[0] = m_pend[0];
                m_comm[1] = m_pend[1];
            end
        end
    end

    task automatic model_out(output logic [2:0] cs, output logic [22:0] off,
                             output logic per, output logic err, output string tag);
        int s;
        cs = '0; off = '0; per = 1'b0; err = 1'b0; tag = "R9";
        if (d_valid) begin
            if (d_addr >= 24'h800000) begin
                s = d_code ? m_comm[0] : m_comm[1];
                tag = d_code ? "R1" : "R2";
            end else if (d_addr >= 24'h7FF800) begin
                s = -1;
                per = 1'b1;
                tag = "R4";
            end else begin
                s = 0;
                tag = "R3";
            end
            if (s >= 0) begin
                if (m_s2[s]) begin
                    cs[s] = 1'b1;
                    off = d_addr[22:0];
                end else begin
                    err = 1'b1;
                    tag = "R5";
                end
            end
        end
    endtask

    // Apply inputs at the falling edge, compare against the model before the next rise
    task automatic step(input logic v, input logic [23:0] a, input logic c,
                        input logic w = 1'b0, input logic t = 1'b0, input logic [1:0] sl = 2'd0);
        logic [2:0]  e_cs;
        logic [22:0] e_off;
        logic        e_per, e_err;
        string       tag;
        @(negedge clk);
        d_valid = v; d_addr = a; d_code = c; d_wr = w; d_tgt = t; d_slot = sl;
        #5;
        model_out(e_cs, e_off, e_per, e_err, tag);
        checks++;
        if (slot_cs !== e_cs || card_offset !== e_off || periph_sel !== e_per || bus_err !== e_err) begin
            errors++;
            $display("FAIL %s: cs=%b off=%h per=%b err=%b expected cs=%b off=%h per=%b err=%b",
                     tag, slot_cs, card_offset, periph_sel, bus_err, e_cs, e_off, e_per, e_err);
        end
    endtask

    // Directed check against hard-coded expectations from the requirements
    task automatic expect_out(input string tag, input logic [2:0] e_cs, input logic e_err,
                              input logic [22:0] e_off);
        checks++;
        if (slot_cs !== e_cs || bus_err !== e_err || card_offset !== e_off) begin
            errors++;
            $display("FAIL %s: cs=%b err=%b off=%h expected cs=%b err=%b off=%h",
                     tag, slot_cs, bus_err, card_offset, e_cs, e_err, e_off);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) step(1'b0, 24'h0, 1'b0);
        @(negedge clk); rst = 1'b0;
        // R10: presence not yet synchronised -> absent
        step(1'b1, 24'h800010, 1'b1);
        expect_out("R10", 3'b000, 1'b1, 23'h0);
        step(1'b0, 24'h0, 1'b0);
        // R10: after sync, both selections default to slot 0
        step(1'b1, 24'h800010, 1'b1);
        expect_out("R10", 3'b001, 1'b0, 23'h000010);
        step(1'b0, 24'h0, 1'b0);
        step(1'b1, 24'h800020, 1'b0);
        expect_out("R10", 3'b001, 1'b0, 23'h000020);

        // R7 idle write then R1 code fetch on slot 1
        step(1'b0, 24'h0, 1'b0, 1'b1, 1'b0, 2'd1);
        step(1'b1, 24'h812345, 1'b1);
        expect_out("R1", 3'b010, 1'b0, 23'h012345);
        step(1'b0, 24'h0, 1'b0, 1'b1, 1'b1, 2'd2);
        // R2 data on slot 2, same address as fetch reaches slot 1
        step(1'b1, 24'h9ABCDE, 1'b0);
        expect_out("R2", 3'b100, 1'b0, 23'h1ABCDE);
        step(1'b0, 24'h0, 1'b0);
        step(1'b1, 24'h9ABCDE, 1'b1);
        expect_out("R1", 3'b010, 1'b0, 23'h1ABCDE);
        step(1'b0, 24'h0, 1'b0);
        step(1'b1, 24'h800000, 1'b0);
        expect_out("R2", 3'b100, 1'b0, 23'h000000);
        step(1'b0, 24'h0, 1'b0);

        // R3 lower half to system slot, both spaces, boundary below peripherals
        step(1'b1, 24'h001000, 1'b1);
        expect_out("R3", 3'b001, 1'b0, 23'h001000);
        step(1'b0, 24'h0, 1'b0);
        step(1'b1, 24'h7FF7FF, 1'b0);
        expect_out("R3", 3'b001, 1'b0, 23'h7FF7FF);
        step(1'b0, 24'h0, 1'b0);
        // R4 peripheral range edges
        step(1'b1, 24'h7FF800, 1'b0);
        expect_out("R4", 3'b000, 1'b0, 23'h0);
        step(1'b0, 24'h0, 1'b0);
        step(1'b1, 24'h7FFFFF, 1'b1);
        expect_out("R4", 3'b000, 1'b0, 23'h0);
        step(1'b0, 24'h0, 1'b0);

        // R7 write during a cycle waits for the idle edge
        step(1'b1, 24'hA00004, 1'b0, 1'b1, 1'b1, 2'd1);
        expect_out("R7", 3'b100, 1'b0, 23'h200004);
        step(1'b1, 24'hA00004, 1'b0);
        expect_out("R7", 3'b100, 1'b0, 23'h200004);
        step(1'b0, 24'h0, 1'b0);
        expect_out("R9", 3'b000, 1'b0, 23'h0);
        step(1'b1, 24'hA00004, 1'b0);
        expect_out("R7", 3'b010, 1'b0, 23'h200004);
        step(1'b0, 24'h0, 1'b0);

        // R8 out-of-range slot ignored
        step(1'b0, 24'h0, 1'b0, 1'b1, 1'b0, 2'd3);
        step(1'b1, 24'hC00000, 1'b1);
        expect_out("R8", 3'b010, 1'b0, 23'h400000);
        step(1'b0, 24'h0, 1'b0);

        // R6 / R5 removal seen after two edges
        @(negedge clk); d_pres = 3'b101;
        #5;
        step(1'b1, 24'hC00000, 1'b1);
        expect_out("R6", 3'b010, 1'b0, 23'h400000);
        step(1'b1, 24'hC00000, 1'b1);
        expect_out("R5", 3'b000, 1'b1, 23'h0);
        step(1'b0, 24'h0, 1'b0);
        // R5 system slot absent in lower half
        @(negedge clk); d_pres = 3'b110;
        #5;
        step(1'b0, 24'h0, 1'b0);
        step(1'b1, 24'h000100, 1'b0);
        expect_out("R5", 3'b000, 1'b1, 23'h0);
        step(1'b0, 24'h0, 1'b0);
        @(negedge clk); d_pres = 3'b111;
        #5;

        // Random traffic compared cycle by cycle against the model
        for (int i = 0; i < 2000; i++) begin
            logic [23:0] a;
            logic        busy;
            int          r;
            r = $urandom_range(0, 3);
            case (r)
                0: a = 24'h7FF800 | 24'($urandom_range(0, 2047));
                1: a = 24'($urandom_range(0, 24'h7FFFFF));
                default: a = 24'h800000 | 24'($urandom_range(0, 24'h7FFFFF));
            endcase
            busy = ($urandom_range(0, 2) != 0) && !d_valid;
            if ($urandom_range(0, 15) == 0) begin
                @(negedge clk); d_pres = 3'($urandom_range(0, 7));
                #1;
            end
            step(busy, a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
                 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule